// File: doc/BRIEF.md
# Signed multiply-accumulate with carry-save feedback

This block multiplies two signed N-bit operands on every accepted cycle and adds the product into a 2N-bit running total. The total is never resolved inside the loop. It is held as a redundant pair of vectors, a sum vector and a carry vector. On the next accepted operation both vectors are fed back into the same compression tree that reduces the new partial products. The loop therefore has no adder for accumulation. The tree is built only from 4-2 compressor rows.

The two lowest bit columns of the tree output are resolved on every accepted cycle by a small lookahead adder. Their carry-out is fed back as a single bit, so the output adder only needs to span the upper 2N-2 bits.

A clear request that arrives with an accepted operation discards the stored total, so the result is the new product alone. The resolved total is registered and comes out with a one-cycle valid flag.

Top module: `csmac_top`

## Requirements
- R1: Every cycle with `in_valid` high adds the two's-complement product of `op_a` and `op_b` to the accumulated total, modulo 2^(2N).
- R2: When `in_clear` and `in_valid` are both high, the total is replaced by the new product alone.
- R3: When `in_valid` is low, the total is unchanged, and `acc_out` keeps its value two edges later.
- R4: The total that includes an operation sampled at clock edge t appears on `acc_out` after edge t+2. `out_valid` is high for exactly that cycle. When no operation was sampled at edge t, `out_valid` is low after edge t+2.
- R5: After synchronous reset, `acc_out` is 0 and `out_valid` is 0. The total is zero, so a first operation without clear yields its product alone.
- R6: The most negative operand value (-2^(N-1)) is handled correctly on either input, including when both inputs take it.
- R7: A total that passes 2^(2N-1)-1 wraps to the two's-complement pattern of the exact sum modulo 2^(2N). For example, with N=8, two products of 16384 give 0x8000.
- R8: `in_clear` has no effect while `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept the operands in this cycle |
| in_clear | input | 1 | Restart the total with this product (qualified by in_valid) |
| op_a | input | N | Signed multiplicand |
| op_b | input | N | Signed multiplier |
| acc_out | output | 2N | Registered accumulated total |
| out_valid | output | 1 | acc_out reflects a newly accepted operation |

## Verification
The properties assume that the inputs are driven to known levels on every edge outside reset. They also assume that `in_clear` is only meaningful together with `in_valid`. The bench drives all inputs half a period away from the sampling edge. It holds them steady through that edge and changes them only between edges. The random phase mixes idle cycles, clears with and without valid, and the extreme operand values. This keeps the wrap, hold and restart cases inside what the properties describe.

// File: rtl/csmac_pkg.sv
package csmac_pkg;

  // One pass of 4-2 compression: every group of up to four rows becomes two.
  function automatic int next_rows(input int r);
    if (r <= 2) return r;
    return 2 * ((r + 3) / 4);
  endfunction

  // Row count after l compression passes.
  function automatic int rows_at(input int r0, input int l);
    int r;
    r = r0;
    for (int i = 0; i < l; i++) r = next_rows(r);
    return r;
  endfunction

  // Number of passes until two rows remain.
  function automatic int tree_levels(input int r0);
    int r;
    int n;
    r = r0;
    n = 0;
    while (r > 2) begin
      r = next_rows(r);
      n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/csmac_ppgen.sv
module csmac_ppgen #(
  parameter int N    = 8,
  parameter int LOWB = 2,
  localparam int W    = 2 * N,
  localparam int ROWS = N + 3
) (
  input  logic [N-1:0]           mcand,
  input  logic [N-1:0]           mplier,
  input  logic [W-1:0]           fb_sum,
  input  logic [W-1:0]           fb_carry,
  input  logic                   fb_low_cy,
  output logic [ROWS-1:0][W-1:0] rows
);

  logic [W-1:0] mcand_ext;
  assign mcand_ext = {{N{mcand[N-1]}}, mcand};

  // Positive-weight rows for the low multiplier bits.
  for (genvar i = 0; i < N - 1; i++) begin : g_pos
    assign rows[i] = mplier[i] ? (mcand_ext << i) : '0;
  end

  // The sign bit of the multiplier carries negative weight. Its row is the
  // one's complement shifted into place; the +1 goes into the correction row.
  assign rows[N-1] = mplier[N-1] ? ((~mcand_ext) << (N - 1)) : '0;

  // Correction row: the two's-complement +1 at bit N-1, plus the fed-back
  // carry out of the pre-resolved low columns at bit LOWB.
  always_comb begin
    rows[N] = '0;
    rows[N][N-1] = mplier[N-1];
    rows[N][LOWB] = fb_low_cy;
  end

  assign rows[N+1] = fb_sum;
  assign rows[N+2] = fb_carry;

endmodule

// File: rtl/csmac_c42row.sv
module csmac_c42row #(
  parameter int W = 16
) (
  input  logic [W-1:0] x0,
  input  logic [W-1:0] x1,
  input  logic [W-1:0] x2,
  input  logic [W-1:0] x3,
  output logic [W-1:0] s,
  output logic [W-1:0] c
);

  logic [W-1:0] t;
  logic [W-1:0] co;
  logic [W-1:0] cy;
  logic [W-1:0] ci;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_first
      assign ci[i] = 1'b0;
    end else begin : g_chain
      assign ci[i] = co[i-1];
    end
    assign t[i]  = x0[i] ^ x1[i] ^ x2[i];
    assign co[i] = (x0[i] & x1[i]) | (x0[i] & x2[i]) | (x1[i] & x2[i]);
    assign s[i]  = t[i] ^ x3[i] ^ ci[i];
    assign cy[i] = (t[i] & x3[i]) | (t[i] & ci[i]) | (x3[i] & ci[i]);
  end

  assign c = {cy[W-2:0], 1'b0};

  // Bits that leave the 2N-bit modulus are dropped on purpose.
  logic unused_top;
  assign unused_top = co[W-1] ^ cy[W-1];

endmodule

// File: rtl/csmac_tree.sv
module csmac_tree
  import csmac_pkg::*;
#(
  parameter int W    = 16,
  parameter int ROWS = 11,
  localparam int NLEV = tree_levels(ROWS)
) (
  input  logic [ROWS-1:0][W-1:0] rows,
  output logic [W-1:0]           sum_v,
  output logic [W-1:0]           carry_v
);

  logic [W-1:0] lv [0:NLEV][0:ROWS-1];

  for (genvar j = 0; j < ROWS; j++) begin : g_in
    assign lv[0][j] = rows[j];
  end

  for (genvar l = 0; l < NLEV; l++) begin : g_lev
    localparam int RI = rows_at(ROWS, l);
    localparam int RO = rows_at(ROWS, l + 1);
    for (genvar g = 0; g < RO / 2; g++) begin : g_grp
      logic [W-1:0] a0, a1, a2, a3;
      assign a0 = lv[l][4*g];
      assign a1 = lv[l][4*g+1];
      if (4 * g + 2 < RI) begin : g_a2
        assign a2 = lv[l][4*g+2];
      end else begin : g_z2
        assign a2 = '0;
      end
      if (4 * g + 3 < RI) begin : g_a3
        assign a3 = lv[l][4*g+3];
      end else begin : g_z3
        assign a3 = '0;
      end
      csmac_c42row #(.W(W)) u_row (
        .x0(a0), .x1(a1), .x2(a2), .x3(a3),
        .s(lv[l+1][2*g]), .c(lv[l+1][2*g+1])
      );
    end
    for (genvar j = RO; j < ROWS; j++) begin : g_pad
      assign lv[l+1][j] = '0;
    end
  end

  assign sum_v   = lv[NLEV][0];
  assign carry_v = lv[NLEV][1];

  logic [W-1:0] unused_pad;
  always_comb begin
    unused_pad = '0;
    for (int j = 2; j < ROWS; j++) unused_pad = unused_pad | lv[NLEV][j];
  end

endmodule

// File: rtl/csmac_lowcla.sv
module csmac_lowcla #(
  parameter int K = 2
) (
  input  logic [K-1:0] a,
  input  logic [K-1:0] b,
  output logic [K-1:0] s,
  output logic         cout
);

  logic [K-1:0] p, g;
  logic [K:0]   c;

  assign p = a ^ b;
  assign g = a & b;

  // Each carry is formed directly from generate/propagate terms.
  always_comb begin
    c = '0;
    for (int j = 0; j < K; j++) begin
      logic any;
      any = 1'b0;
      for (int i = 0; i <= j; i++) begin
        logic term;
        term = g[i];
        for (int m = i + 1; m <= j; m++) term = term & p[m];
        any = any | term;
      end
      c[j+1] = any;
    end
  end

  assign s    = p ^ c[K-1:0];
  assign cout = c[K];

endmodule

// File: rtl/csmac_top.sv
module csmac_top #(
  parameter int N    = 8,
  parameter int LOWB = 2,
  localparam int W    = 2 * N,
  localparam int ROWS = N + 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic         in_clear,
  input  logic [N-1:0] op_a,
  input  logic [N-1:0] op_b,
  output logic [W-1:0] acc_out,
  output logic         out_valid
);

  logic [W-1:0] sum_q, carry_q;
  logic         lowcy_q;
  logic         v1_q;

  logic [W-1:0] fb_sum, fb_carry;
  logic         fb_lowcy;

  // A clear substitutes zeros for the fed-back redundant total.
  assign fb_sum   = in_clear ? '0 : sum_q;
  assign fb_carry = in_clear ? '0 : carry_q;
  assign fb_lowcy = in_clear ? 1'b0 : lowcy_q;

  logic [ROWS-1:0][W-1:0] rows;

  csmac_ppgen #(.N(N), .LOWB(LOWB)) u_pp (
    .mcand(op_a), .mplier(op_b),
    .fb_sum(fb_sum), .fb_carry(fb_carry), .fb_low_cy(fb_lowcy),
    .rows(rows)
  );

  logic [W-1:0] t_sum, t_carry;

  csmac_tree #(.W(W), .ROWS(ROWS)) u_tree (
    .rows(rows), .sum_v(t_sum), .carry_v(t_carry)
  );

  logic [LOWB-1:0] low_res;
  logic            low_cy;

  csmac_lowcla #(.K(LOWB)) u_cla (
    .a(t_sum[LOWB-1:0]), .b(t_carry[LOWB-1:0]),
    .s(low_res), .cout(low_cy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q   <= '0;
      carry_q <= '0;
      lowcy_q <= 1'b0;
      v1_q    <= 1'b0;
    end else begin
      v1_q <= in_valid;
      if (in_valid) begin
        sum_q   <= {t_sum[W-1:LOWB], low_res};
        carry_q <= {t_carry[W-1:LOWB], {LOWB{1'b0}}};
        lowcy_q <= low_cy;
      end
    end
  end

  // Narrow output adder: only the columns above the pre-resolved bits.
  logic [W-LOWB-1:0] hi_sum;
  assign hi_sum = sum_q[W-1:LOWB] + carry_q[W-1:LOWB] + {{(W-LOWB-1){1'b0}}, lowcy_q};

  logic [LOWB-1:0] unused_clow;
  assign unused_clow = carry_q[LOWB-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_out   <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= v1_q;
      if (v1_q) acc_out <= {hi_sum, sum_q[LOWB-1:0]};
    end
  end

endmodule

// File: rtl/csmac_chk.sv
module csmac_chk #(
  parameter int N = 8,
  localparam int W = 2 * N
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_clear,
  input logic [N-1:0] op_a,
  input logic [N-1:0] op_b,
  input logic [W-1:0] acc_out,
  input logic         out_valid
);

  logic signed [W-1:0] prod_c;
  assign prod_c = $signed(op_a) * $signed(op_b);

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid); // R4

  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ##1 !out_valid); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ##1 $stable(acc_out)); // R3

  AST_CLEAR_PRODUCT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_clear) |=> ##1 (acc_out == $past(prod_c, 2))); // R2

  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_clear && (op_a == '0)) |=> ##1 (acc_out == '0)); // R1

endmodule

bind csmac_top csmac_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_clear(in_clear),
  .op_a(op_a), .op_b(op_b), .acc_out(acc_out), .out_valid(out_valid)
);

// File: tb/csmac_top_tb.sv
module csmac_top_tb;
  localparam int N = 8;
  localparam int W = 2 * N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_clear = 1'b0;
  logic [N-1:0] op_a = '0, op_b = '0;
  logic [W-1:0] acc_out;
  logic out_valid;

  always #10 clk = ~clk;

  csmac_top #(.N(N)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_clear(in_clear),
    .op_a(op_a), .op_b(op_b), .acc_out(acc_out), .out_valid(out_valid)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  string phase = "R5";

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Behavioural cycle model.
  logic [W-1:0] m_acc = '0, m_res = '0;
  logic m_v1 = 0, m_ov = 0;
  always @(posedge clk) begin
    if (rst) begin
      m_acc <= '0; m_res <= '0; m_v1 <= 0; m_ov <= 0;
    end else begin
      logic signed [W-1:0] p;
      p = $signed(op_a) * $signed(op_b);
      m_ov <= m_v1;
      if (m_v1) m_res <= m_acc;
      m_v1 <= in_valid;
      if (in_valid) m_acc <= (in_clear ? '0 : m_acc) + p;
    end
  end

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk({phase, " acc"}, acc_out, m_res);
      chk("R4 valid", {{(W-1){1'b0}}, out_valid}, {{(W-1){1'b0}}, m_ov});
    end
  end

  task automatic op(input logic v, input logic c, input logic [N-1:0] a, input logic [N-1:0] b);
    @(negedge clk); #1;
    in_valid = v; in_clear = c; op_a = a; op_b = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) op(0, 0, N'($urandom), N'($urandom));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk("R5 reset acc", acc_out, '0);
    chk("R5 reset valid", {{(W-1){1'b0}}, out_valid}, '0);
    // R5: first operation without clear yields the product alone
    phase = "R5";
    op(1, 0, 8'd7, 8'd9); idle(2);
    @(negedge clk); chk("R5 first", acc_out, 16'd63);
    // R2: clear restarts with product
    phase = "R2";
    op(1, 1, 8'd3, -8'sd5); idle(2);
    @(negedge clk); chk("R2 clear", acc_out, 16'hFFF1);
    // R6 / R7: most negative operands and wrap
    phase = "R6";
    op(1, 1, 8'h80, 8'h80); idle(2);
    @(negedge clk); chk("R6 minneg", acc_out, 16'h4000);
    phase = "R7";
    op(1, 0, 8'h80, 8'h80); idle(2);
    @(negedge clk); chk("R7 wrap", acc_out, 16'h8000);
    // R8: clear without valid is ignored
    phase = "R8";
    op(0, 1, 8'd5, 8'd5); op(1, 0, 8'd1, 8'd1); idle(2);
    @(negedge clk); chk("R8 ignored clear", acc_out, 16'h8001);
    // R3: idle cycles hold the total
    phase = "R3";
    idle(5);
    @(negedge clk); chk("R3 hold", acc_out, 16'h8001);
    // R6: min negative against positive
    phase = "R6";
    op(1, 1, 8'h80, 8'h7F); idle(2);
    @(negedge clk); chk("R6 min*max", acc_out, 16'hC080);
    // R1: random stream with extremes, clears and gaps
    phase = "R1";
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] a, b;
      int k;
      k = $urandom_range(0, 9);
      a = (k == 0) ? 8'h80 : (k == 1) ? 8'h7F : N'($urandom);
      b = (k == 2) ? 8'h80 : (k == 3) ? 8'hFF : N'($urandom);
      op($urandom_range(0, 3) != 0, $urandom_range(0, 15) == 0, a, b);
    end
    idle(4);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule